// File: doc/BRIEF.md
# UART Interrupt Mask and Routing

This block holds the interrupt state of a serial port. Eleven raw status bits are set by one-cycle event pulses from the surrounding data path: four modem-line changes, receive, transmit, receive timeout and four error kinds. The transmit bit is also set when software writes the data address. An enable mask selects which raw bits may raise an interrupt. The block drives six registered interrupt lines. One line is combined over all groups. The other five are dedicated to receive, transmit, timeout, modem status and error.

Software reaches the block through a small register port with a 3-bit address and a write strobe. Read data is combinational. The address map is: 0 raw status (read only), 1 enable mask (read/write), 2 masked status (read only), 3 clear (write only, reads zero) and 4 data (write only, reads zero). Addresses 5 to 7 read zero and ignore writes. Status bits occupy data bits 10:0, and upper data bits read as zero. Bit layout: bits 3:0 are modem status (ring, clear-to-send, carrier, data-set-ready), bit 4 is receive, bit 5 is transmit, bit 6 is receive timeout, and bits 10:7 are errors (framing, parity, break, overrun).

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, raw status, enable mask and all six interrupt lines are zero.
- R2: A read of address 2 returns the bitwise AND of raw status and enable mask in bits 10:0.
- R3: A write to address 3 clears each raw bit whose data bit is 1 and leaves the others unchanged. A read of address 3 returns zero.
- R4: Writes to address 0 and address 2 change neither raw status nor enable mask.
- R5: The combined line is high exactly when any masked bit among bits 10:0 is set.
- R6: Each dedicated line reflects only its own masked group: receive bit 4, transmit bit 5, timeout bit 6, modem status bits 3:0, error bits 10:7.
- R7: A write to address 4 sets raw bit 5.
- R8: An event pulse on bit n sets raw bit n. If the same bit is cleared in the same cycle, the set wins.
- R9: The interrupt lines are registered. They take their new value at the same clock edge that updates raw status or mask.
- R10: A write to address 1 replaces the enable mask with data bits 10:0. A read of address 1 returns the mask, with upper bits zero. Addresses 4 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| ev_set | input | 11 | One-cycle event pulses, one per raw bit |
| irq_all | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rt | output | 1 | Receive timeout interrupt |
| irq_ms | output | 1 | Modem status interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The event path and the software clear can hit the same raw bit in the same cycle. By the ordering rule the set must survive. The bench provokes this with directed cases that pulse an event while clearing the same bit, and also while clearing a neighbouring bit. It then reads the raw status and the dedicated line on the next cycle. Random traffic adds many more such collisions, each judged against a bench model that applies clear before set.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IRQ_W     = 11;
    localparam int NUM_LINES = 6;

    localparam int BIT_RX = 4;
    localparam int BIT_TX = 5;
    localparam int BIT_RT = 6;

    localparam logic [IRQ_W-1:0] GRP_MODEM = 11'h00F;
    localparam logic [IRQ_W-1:0] GRP_RX    = 11'h010;
    localparam logic [IRQ_W-1:0] GRP_TX    = 11'h020;
    localparam logic [IRQ_W-1:0] GRP_RT    = 11'h040;
    localparam logic [IRQ_W-1:0] GRP_ERR   = 11'h780;
    localparam logic [IRQ_W-1:0] GRP_ALL   =
        GRP_MODEM | GRP_RX | GRP_TX | GRP_RT | GRP_ERR;

    typedef enum logic [2:0] {
        SEL_RAW    = 3'd0,
        SEL_MASK   = 3'd1,
        SEL_MASKED = 3'd2,
        SEL_CLEAR  = 3'd3,
        SEL_DATA   = 3'd4
    } reg_sel_e;

    typedef enum int {
        LINE_ALL = 0,
        LINE_RX  = 1,
        LINE_TX  = 2,
        LINE_RT  = 3,
        LINE_MS  = 4,
        LINE_ERR = 5
    } line_e;

    typedef struct packed {
        logic mask_wr;
        logic clear_wr;
        logic data_wr;
    } strobe_t;

    typedef struct packed {
        logic [IRQ_W-1:0] raw;
        logic [IRQ_W-1:0] mask;
    } irq_state_t;

    function automatic logic [IRQ_W-1:0] line_group(input int line);
        case (line)
            LINE_ALL: line_group = GRP_ALL;
            LINE_RX:  line_group = GRP_RX;
            LINE_TX:  line_group = GRP_TX;
            LINE_RT:  line_group = GRP_RT;
            LINE_MS:  line_group = GRP_MODEM;
            default:  line_group = GRP_ERR;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output strobe_t           strb
);
    reg_sel_e sel;

    always_comb begin
        sel = reg_sel_e'(addr[2:0]);
        strb = '0;
        if (wr) begin
            case (sel)
                SEL_MASK:  strb.mask_wr  = 1'b1;
                SEL_CLEAR: strb.clear_wr = 1'b1;
                SEL_DATA:  strb.data_wr  = 1'b1;
                default:   strb = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          strb,
    input  logic [IRQ_W-1:0] wbits,
    input  logic [IRQ_W-1:0] ev_set,
    output irq_state_t       st_q,
    output irq_state_t       st_d
);
    logic [IRQ_W-1:0] clr_vec;
    logic [IRQ_W-1:0] set_vec;

    always_comb begin
        clr_vec = strb.clear_wr ? wbits : '0;
        set_vec = ev_set;
        if (strb.data_wr) begin
            set_vec[BIT_TX] = 1'b1;
        end
        st_d.raw  = (st_q.raw & ~clr_vec) | set_vec;
        st_d.mask = strb.mask_wr ? wbits : st_q.mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
    import uart_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IRQ_W-1:0]     masked_d,
    output logic [NUM_LINES-1:0] lines_q
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam logic [IRQ_W-1:0] GM = line_group(g);
        logic hit;
        assign hit = |(masked_d & GM);
        always_ff @(posedge clk) begin
            if (rst) begin
                lines_q[g] <= 1'b0;
            end else begin
                lines_q[g] <= hit;
            end
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [IRQ_W-1:0]  ev_set,
    output logic              irq_all,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_rt,
    output logic              irq_ms,
    output logic              irq_err
);
    localparam int PAD_W = DATA_W - IRQ_W;

    strobe_t               strb;
    irq_state_t            st_q;
    irq_state_t            st_d;
    logic [IRQ_W-1:0]      raw_q;
    logic [IRQ_W-1:0]      mask_q;
    logic [IRQ_W-1:0]      rd_bits;
    logic [NUM_LINES-1:0]  lines_q;

    uart_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .wr   (reg_wr),
        .strb (strb)
    );

    uart_irq_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .strb   (strb),
        .wbits  (reg_wdata[IRQ_W-1:0]),
        .ev_set (ev_set),
        .st_q   (st_q),
        .st_d   (st_d)
    );

    uart_irq_route u_route (
        .clk      (clk),
        .rst      (rst),
        .masked_d (st_d.raw & st_d.mask),
        .lines_q  (lines_q)
    );

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;

    always_comb begin
        case (reg_sel_e'(reg_addr[2:0]))
            SEL_RAW:    rd_bits = raw_q;
            SEL_MASK:   rd_bits = mask_q;
            SEL_MASKED: rd_bits = raw_q & mask_q;
            default:    rd_bits = '0;
        endcase
    end

    assign reg_rdata = {{PAD_W{1'b0}}, rd_bits};

    assign irq_all = lines_q[LINE_ALL];
    assign irq_rx  = lines_q[LINE_RX];
    assign irq_tx  = lines_q[LINE_TX];
    assign irq_rt  = lines_q[LINE_RT];
    assign irq_ms  = lines_q[LINE_MS];
    assign irq_err = lines_q[LINE_ERR];
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [IRQ_W-1:0]  ev_set,
    input logic [IRQ_W-1:0]  raw_q,
    input logic [IRQ_W-1:0]  mask_q,
    input logic              irq_all,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic              irq_rt,
    input logic              irq_ms,
    input logic              irq_err
);
    a_r1_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> (raw_q == '0 && mask_q == '0 && !irq_all && !irq_err));

    a_r2_masked_read: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 3'd2) |-> (reg_rdata[IRQ_W-1:0] == (raw_q & mask_q)));

    a_r3_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 3'd3) |-> (reg_rdata == '0));

    a_r3_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd3) |=>
        ((raw_q & $past(reg_wdata[IRQ_W-1:0] & ~ev_set)) == '0));

    a_r4_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd2) && ev_set == '0) |=>
        (raw_q == $past(raw_q) && mask_q == $past(mask_q)));

    a_r5_combined_or: assert property (@(posedge clk) disable iff (rst)
        irq_all == (irq_rx | irq_tx | irq_rt | irq_ms | irq_err));

    a_r7_data_sets_tx: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd4) |=> raw_q[BIT_TX]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (ev_set != '0) |=> ((raw_q & $past(ev_set)) == $past(ev_set)));

    a_r9_lines_track_state: assert property (@(posedge clk) disable iff (rst)
        (irq_rx == (raw_q[BIT_RX] & mask_q[BIT_RX])) &&
        (irq_ms == |(raw_q & mask_q & GRP_MODEM)));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ev_set    (ev_set),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .irq_all   (irq_all),
    .irq_rx    (irq_rx),
    .irq_tx    (irq_tx),
    .irq_rt    (irq_rt),
    .irq_ms    (irq_ms),
    .irq_err   (irq_err)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [10:0] ev_set = '0;
    logic        irq_all, irq_rx, irq_tx, irq_rt, irq_ms, irq_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [10:0] m_raw = '0;
    logic [10:0] m_mask = '0;

    always #5 clk = ~clk;

    uart_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_set(ev_set),
        .irq_all(irq_all), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .irq_rt(irq_rt), .irq_ms(irq_ms), .irq_err(irq_err)
    );

    function automatic logic [15:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return {5'd0, m_raw};
            3'd1:    return {5'd0, m_mask};
            3'd2:    return {5'd0, m_raw & m_mask};
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic [5:0] exp_lines();
        logic [10:0] m;
        m = m_raw & m_mask;
        return {|m[10:7], |m[3:0], m[6], m[5], m[4], |m};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step(input logic [2:0] a, input logic w, input logic [15:0] d,
                              input logic [10:0] ev);
        logic [10:0] clr;
        logic [10:0] st;
        clr = (w && a == 3'd3) ? d[10:0] : '0;
        st = ev;
        if (w && a == 3'd4) st[5] = 1'b1;
        if (w && a == 3'd1) m_mask = d[10:0];
        m_raw = (m_raw & ~clr) | st;
    endtask

    task automatic cyc(input logic [2:0] a, input logic w, input logic [15:0] d,
                       input logic [10:0] ev, input string req);
        reg_addr = a; reg_wr = w; reg_wdata = d; ev_set = ev;
        #1;
        check({req, " rdata R2 R10"}, {16'd0, reg_rdata}, {16'd0, exp_read(a)});
        @(posedge clk);
        model_step(a, w, d, ev);
        #1;
        check({req, " lines R5 R6 R9"},
              {26'd0, irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_all},
              {26'd0, exp_lines()});
        @(negedge clk);
        reg_wr = 1'b0; ev_set = '0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 irq lines", {26'd0, irq_err, irq_ms, irq_rt, irq_tx, irq_rx, irq_all}, 32'd0);
        reg_addr = 3'd0; #1; check("R1 raw", {16'd0, reg_rdata}, 32'd0);
        reg_addr = 3'd1; #1; check("R1 mask", {16'd0, reg_rdata}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R10: mask write with upper bits, read back
        cyc(3'd1, 1'b1, 16'hFFFF, '0, "R10 mask all");
        cyc(3'd1, 1'b0, '0, '0, "R10 mask readback");
        // R8: event sets bits
        cyc(3'd0, 1'b0, '0, 11'h010, "R8 rx event");
        cyc(3'd0, 1'b0, '0, 11'h000, "R6 rx line");
        // R7: data write sets tx
        cyc(3'd4, 1'b1, 16'h0041, '0, "R7 data write");
        cyc(3'd0, 1'b0, '0, '0, "R7 tx raw");
        // R4: writes to raw / masked ignored
        cyc(3'd0, 1'b1, 16'h07FF, '0, "R4 raw write");
        cyc(3'd2, 1'b1, 16'h0000, '0, "R4 masked write");
        cyc(3'd0, 1'b0, '0, '0, "R4 raw unchanged");
        // R3: clear, reads zero
        cyc(3'd3, 1'b1, 16'h0010, '0, "R3 clear rx");
        cyc(3'd3, 1'b0, '0, '0, "R3 clear reads zero");
        // R8: set and clear same bit same cycle
        cyc(3'd3, 1'b1, 16'h0180, 11'h080, "R8 set vs clear");
        cyc(3'd0, 1'b0, '0, '0, "R8 set survives");
        // R6: groups in isolation with partial mask
        cyc(3'd3, 1'b1, 16'h07FF, '0, "R3 clear all");
        cyc(3'd1, 1'b1, 16'h0408, '0, "R6 partial mask");
        cyc(3'd0, 1'b0, '0, 11'h004, "R6 unmasked modem");
        cyc(3'd0, 1'b0, '0, 11'h008, "R6 masked modem");
        cyc(3'd0, 1'b0, '0, 11'h200, "R6 unmasked error");
        cyc(3'd0, 1'b0, '0, 11'h400, "R6 masked error");
        cyc(3'd2, 1'b0, '0, 11'h040, "R2 masked read");
        cyc(3'd5, 1'b1, 16'hFFFF, '0, "R10 unused addr");
        cyc(3'd1, 1'b1, 16'h0000, '0, "R9 mask drop");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  a;
            logic        w;
            logic [15:0] d;
            logic [10:0] ev;
            a = 3'($urandom_range(0, 7));
            w = 1'($urandom_range(0, 1));
            d = 16'($urandom);
            ev = ($urandom_range(0, 3) == 0) ? 11'($urandom & $urandom) : 11'd0;
            cyc(a, w, d, ev, "R8 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule